// File: doc/BRIEF.md
# Byte Window Reader for a Word-Only Fuse Store

This block lets a client read any run of bytes from a fuse array that can only be read one 32-bit word at a time. The client hands over a byte offset and a byte count on a command channel. The block finds the aligned range of words that covers the requested bytes and fetches those words one by one through a request/response port. It splits each returned word into bytes, lowest byte first, and streams out exactly the bytes that were asked for. Bytes in front of the requested offset and bytes behind its end are dropped.

A plain control pin, sampled with each command, adds a fixed hidden base of 96 bytes to the caller's offset. The caller then sees only the top 32 bytes of a 128-byte store, and the lower region is unreachable through offsets that stay inside the visible window. A word fetch that comes back with an error ends the transfer at once and raises a sticky error flag. A command with zero length finishes straight away and fetches nothing.

Command, word request, word response and byte output are each valid/ready channels. A transfer moves only on cycles where both valid and ready are high. A producer holding valid high must keep its payload steady until the transfer happens. Back-pressure on the byte output stalls the whole pipeline: no new word response is accepted until the word register has room.

Top module: `fuse_byte_window`

## Requirements
- R1: For effective offset E and length L > 0, the block issues exactly ceil((E+L)/4) - floor(E/4) word requests. The addresses start at floor(E/4) and rise by one per request.
- R2: Word request addresses are the word index modulo 1024 (10 bits), so the index after 1023 is sent as address 0.
- R3: Within a returned word, byte j sits on bits 8j+7..8j, and the bytes of a word leave the output in ascending j.
- R4: The first output byte is byte (E mod 4) of the first word. Exactly L bytes are emitted, and out_last is high on the final byte only.
- R5: When hide_base is high at command acceptance, E = offset + 96; otherwise E = offset.
- R6: At most one word request is outstanding. No new request is made until the response to the previous one has been accepted.
- R7: A response with wrsp_err high ends the transfer. No further bytes or requests follow, and err goes high and stays high until the next command is accepted. A command that completes normally leaves err low.
- R8: A command with length 0 issues no word request and emits no byte, and done goes high in the cycle after acceptance.
- R9: cmd_ready is high only while the block is idle. While wreq_valid is high and wreq_ready is low, wreq_valid and wreq_addr hold. While out_valid is high and out_ready is low, out_valid, out_data and out_last hold.
- R10: done is a one-cycle pulse in the cycle after the transfer ends. The end is the final byte being accepted, an error response being accepted, or a zero-length command being accepted. busy is low while done is high.
- R11: During and right after reset, cmd_ready is high, and busy, done, err, wreq_valid and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_offset | input | 16 | Byte offset of the first requested byte |
| cmd_len | input | 16 | Number of bytes requested |
| hide_base | input | 1 | Adds the hidden 96-byte base; sampled with the command |
| wreq_valid | output | 1 | Word request offered |
| wreq_ready | input | 1 | Fuse store takes the request |
| wreq_addr | output | 10 | Word address |
| wrsp_valid | input | 1 | Word response offered |
| wrsp_ready | output | 1 | Block takes the response |
| wrsp_data | input | 32 | Word read from the store |
| wrsp_err | input | 1 | Response carries an error |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transfer ended on an error response |

## Verification
Two events can land on the same clock edge: the consumer takes the last pending byte of one word, and the word register is refilled from the next word response. The sweep provokes this by letting the responder park a response on wrsp_valid while the output drains, with out_ready either always high or gated by a pseudo-random bit. The coincidence is judged purely from the byte stream. Every emitted byte is compared against a value computed arithmetically from its effective address. The byte count and the out_last position must match the requested length, so a dropped, repeated or reordered byte at the refill edge is reported.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  // default geometry of the fuse store and the caller-facing window
  localparam int unsigned FBW_BYTE_W      = 8;
  localparam int unsigned FBW_WORD_BYTES  = 4;
  localparam int unsigned FBW_ADDR_W      = 10;
  localparam int unsigned FBW_HIDDEN_BASE = 96;
  localparam int unsigned FBW_OFS_W       = 16;
  localparam int unsigned FBW_LEN_W       = 16;

  // what ended a transfer; drives the completion flags at the top
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_EMPTY = 2'd1,
    END_LAST  = 2'd2,
    END_ABORT = 2'd3
  } fbw_end_e;

endpackage

// File: rtl/fbw_span_calc.sv
// Combinational range arithmetic: effective offset, first word, word count,
// head skip. Evaluated on the command channel and captured at acceptance.
module fbw_span_calc #(
  parameter int unsigned OFS_W       = 16,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned HIDDEN_BASE = 96,
  parameter int unsigned ADDR_W      = 10,
  localparam int unsigned SKIP_W     = $clog2(WORD_BYTES),
  localparam int unsigned EW         = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 2,
  localparam int unsigned IDX_W      = EW - SKIP_W
) (
  input  logic [OFS_W-1:0]  offset,
  input  logic [LEN_W-1:0]  len,
  input  logic              base_en,
  output logic [ADDR_W-1:0] first_word,
  output logic [IDX_W-1:0]  word_cnt,
  output logic [SKIP_W-1:0] head_skip
);

  logic [EW-1:0] eff;
  logic [EW-1:0] end_byte;
  logic [EW-1:0] first_full;
  logic [EW-1:0] end_full;
  logic [EW-1:0] cnt_full;

  always_comb begin
    eff        = EW'(offset) + (base_en ? EW'(HIDDEN_BASE) : '0);
    end_byte   = eff + EW'(len) + EW'(WORD_BYTES - 1);
    first_full = eff >> SKIP_W;
    end_full   = end_byte >> SKIP_W;
    cnt_full   = end_full - first_full;
    first_word = ADDR_W'(first_full);
    word_cnt   = IDX_W'(cnt_full);
    head_skip  = eff[SKIP_W-1:0];
  end

endmodule

// File: rtl/fbw_word_seq.sv
// Issues word reads one at a time and decides, per returned word, which
// byte lane to start at and how many bytes of it belong to the window.
module fbw_word_seq #(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned IDX_W      = 16,
  localparam int unsigned SKIP_W    = $clog2(WORD_BYTES),
  localparam int unsigned NUM_W     = SKIP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_word,
  input  logic [IDX_W-1:0]  word_cnt,
  input  logic [SKIP_W-1:0] head_skip,
  input  logic [LEN_W-1:0]  len,
  output logic              wreq_valid,
  input  logic              wreq_ready,
  output logic [ADDR_W-1:0] wreq_addr,
  input  logic              wrsp_valid,
  output logic              wrsp_ready,
  input  logic              wrsp_err,
  input  logic              lane_free,
  output logic              ld_en,
  output logic [SKIP_W-1:0] ld_start,
  output logic [NUM_W-1:0]  ld_cnt,
  output logic              ld_final,
  output logic              abort,
  output logic              active
);

  logic              active_q;
  logic              wait_q;
  logic [IDX_W-1:0]  words_left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              head_q;
  logic [SKIP_W-1:0] skip_q;
  logic [LEN_W-1:0]  bytes_left_q;

  logic              take;
  logic [NUM_W-1:0]  room;

  assign active     = active_q;
  assign wreq_valid = active_q && !wait_q && (words_left_q != '0);
  assign wreq_addr  = addr_q;
  assign wrsp_ready = active_q && wait_q && lane_free;
  assign take       = wrsp_valid && wrsp_ready;

  always_comb begin
    ld_start = head_q ? skip_q : '0;
    room     = NUM_W'(WORD_BYTES) - NUM_W'(ld_start);
    if (LEN_W'(room) > bytes_left_q) ld_cnt = NUM_W'(bytes_left_q);
    else                             ld_cnt = room;
    ld_final = (bytes_left_q == LEN_W'(ld_cnt));
    ld_en    = take && !wrsp_err;
    abort    = take && wrsp_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      wait_q       <= 1'b0;
      words_left_q <= '0;
      addr_q       <= '0;
      head_q       <= 1'b0;
      skip_q       <= '0;
      bytes_left_q <= '0;
    end else if (start) begin
      active_q     <= 1'b1;
      wait_q       <= 1'b0;
      words_left_q <= word_cnt;
      addr_q       <= first_word;
      head_q       <= 1'b1;
      skip_q       <= head_skip;
      bytes_left_q <= len;
    end else begin
      if (wreq_valid && wreq_ready) begin
        wait_q       <= 1'b1;
        words_left_q <= words_left_q - 1'b1;
        addr_q       <= addr_q + 1'b1;
      end
      if (take) begin
        wait_q <= 1'b0;
        if (wrsp_err) begin
          active_q <= 1'b0;
        end else begin
          head_q       <= 1'b0;
          bytes_left_q <= bytes_left_q - LEN_W'(ld_cnt);
          if (ld_final) active_q <= 1'b0;
        end
      end
    end
  end

  // R9: a stalled request keeps its address
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_valid && !wreq_ready |=> wreq_valid && $stable(wreq_addr));

  // R1: the byte budget runs out on exactly the last word of the range
  p_span_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> (ld_final == (words_left_q == '0)));

  // R6: a response is only taken while a request is outstanding
  p_single_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsp_valid && wrsp_ready) |-> !wreq_valid);

endmodule

// File: rtl/fbw_byte_unpack.sv
// Holds one word and presents its window bytes lowest lane first.
module fbw_byte_unpack #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES,
  localparam int unsigned SKIP_W    = $clog2(WORD_BYTES),
  localparam int unsigned NUM_W     = SKIP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_word,
  input  logic [SKIP_W-1:0] ld_start,
  input  logic [NUM_W-1:0]  ld_cnt,
  input  logic              ld_final,
  output logic              lane_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);

  logic [WORD_W-1:0] word_q;
  logic [SKIP_W-1:0] lane_q;
  logic [NUM_W-1:0]  left_q;
  logic              final_q;
  logic              fire;
  logic [BYTE_W-1:0] lanes [WORD_BYTES];

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lanes[g] = word_q[g*BYTE_W +: BYTE_W];
  end

  assign out_valid = (left_q != '0);
  assign out_data  = lanes[lane_q];
  assign out_last  = final_q && (left_q == NUM_W'(1));
  assign fire      = out_valid && out_ready;
  assign lane_free = (left_q == '0) || (fire && left_q == NUM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      lane_q  <= '0;
      left_q  <= '0;
      final_q <= 1'b0;
    end else if (ld_en) begin
      word_q  <= ld_word;
      lane_q  <= ld_start;
      left_q  <= ld_cnt;
      final_q <= ld_final;
    end else if (fire) begin
      lane_q <= lane_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  // R9: a stalled output byte is held
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R3: a load never lands on bytes that are still pending
  p_load_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> (!out_valid || (out_ready && !($past(ld_en) && 1'b0) && left_q == NUM_W'(1))));

endmodule

// File: rtl/fuse_byte_window.sv
module fuse_byte_window #(
  parameter int unsigned OFS_W       = fbw_pkg::FBW_OFS_W,
  parameter int unsigned LEN_W       = fbw_pkg::FBW_LEN_W,
  parameter int unsigned ADDR_W      = fbw_pkg::FBW_ADDR_W,
  parameter int unsigned BYTE_W      = fbw_pkg::FBW_BYTE_W,
  parameter int unsigned WORD_BYTES  = fbw_pkg::FBW_WORD_BYTES,
  parameter int unsigned HIDDEN_BASE = fbw_pkg::FBW_HIDDEN_BASE,
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES,
  localparam int unsigned SKIP_W     = $clog2(WORD_BYTES),
  localparam int unsigned NUM_W      = SKIP_W + 1,
  localparam int unsigned EW         = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 2,
  localparam int unsigned IDX_W      = EW - SKIP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OFS_W-1:0]  cmd_offset,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              hide_base,
  output logic              wreq_valid,
  input  logic              wreq_ready,
  output logic [ADDR_W-1:0] wreq_addr,
  input  logic              wrsp_valid,
  output logic              wrsp_ready,
  input  logic [WORD_W-1:0] wrsp_data,
  input  logic              wrsp_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              busy,
  output logic              done,
  output logic              err
);

  import fbw_pkg::*;

  logic [ADDR_W-1:0] sp_first;
  logic [IDX_W-1:0]  sp_cnt;
  logic [SKIP_W-1:0] sp_skip;
  logic              cmd_take;
  logic              start;
  logic              seq_active;
  logic              lane_free;
  logic              ld_en;
  logic [SKIP_W-1:0] ld_start;
  logic [NUM_W-1:0]  ld_cnt;
  logic              ld_final;
  logic              abort;
  fbw_end_e          end_kind;
  logic              done_q;
  logic              err_q;

  fbw_span_calc #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES),
    .HIDDEN_BASE(HIDDEN_BASE), .ADDR_W(ADDR_W)
  ) u_span (
    .offset(cmd_offset), .len(cmd_len), .base_en(hide_base),
    .first_word(sp_first), .word_cnt(sp_cnt), .head_skip(sp_skip)
  );

  fbw_word_seq #(
    .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_word(sp_first), .word_cnt(sp_cnt), .head_skip(sp_skip), .len(cmd_len),
    .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_addr(wreq_addr),
    .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .wrsp_err(wrsp_err),
    .lane_free(lane_free), .ld_en(ld_en), .ld_start(ld_start), .ld_cnt(ld_cnt),
    .ld_final(ld_final), .abort(abort), .active(seq_active)
  );

  fbw_byte_unpack #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)
  ) u_unpack (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(wrsp_data),
    .ld_start(ld_start), .ld_cnt(ld_cnt), .ld_final(ld_final),
    .lane_free(lane_free), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  assign busy      = seq_active || out_valid;
  assign cmd_ready = !busy;
  assign cmd_take  = cmd_valid && cmd_ready;
  assign start     = cmd_take && (cmd_len != '0);

  always_comb begin
    if (abort)                             end_kind = END_ABORT;
    else if (out_valid && out_ready && out_last) end_kind = END_LAST;
    else if (cmd_take && cmd_len == '0)    end_kind = END_EMPTY;
    else                                   end_kind = END_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= (end_kind != END_NONE);
      if (cmd_take)                  err_q <= 1'b0;
      else if (end_kind == END_ABORT) err_q <= 1'b1;
    end
  end

  assign done = done_q;
  assign err  = err_q;

  // R7: after an abort nothing more leaves the block
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid && !wreq_valid);

  // R10: the completion pulse finds the block idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: an empty command completes next cycle without a request
  p_empty_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_len == '0) |=> done && !wreq_valid && !out_valid);

endmodule

// File: tb/sim_fuse_byte_window.sv
module sim_fuse_byte_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_offset = '0;
  logic [15:0] cmd_len = '0;
  logic        hide_base = 1'b0;
  logic        wreq_valid;
  logic        wreq_ready = 1'b0;
  logic [9:0]  wreq_addr;
  logic        wrsp_valid = 1'b0;
  logic        wrsp_ready;
  logic [31:0] wrsp_data = '0;
  logic        wrsp_err = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic        busy;
  logic        done;
  logic        err;

  always #2.5 clk = ~clk;

  fuse_byte_window u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_offset(cmd_offset), .cmd_len(cmd_len), .hide_base(hide_base),
    .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_addr(wreq_addr),
    .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .wrsp_data(wrsp_data),
    .wrsp_err(wrsp_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .busy(busy), .done(done), .err(err)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    evt_cyc = 0;
  int    exp_eff = 0;
  int    exp_len = 0;
  int    exp_first = 0;
  int    err_k = -1;
  int    byte_idx = 0;
  int    req_idx = 0;
  bit    sink_rand = 1'b0;
  string addr_tag = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fuse_word(input logic [9:0] a);
    return {a[9:2] ^ 8'h3C, a[7:0] + 8'h11, ~a[7:0], a[7:0]};
  endfunction

  function automatic logic [7:0] exp_byte(input int eb);
    logic [31:0] w;
    w = fuse_word(10'((eb >> 2) & 1023));
    return w[8*(eb & 3) +: 8];
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // word store responder
  initial begin
    bit          pend = 1'b0;
    bit          pend_err = 1'b0;
    bit          taken = 1'b0;
    bit          stall = 1'b0;
    logic [9:0]  paddr = '0;
    logic [9:0]  stall_addr = '0;
    int          dly = 0;
    logic [31:0] s = 32'h1234_5678;
    forever begin
      @(negedge clk);
      s = s * 32'd1664525 + 32'd1013904223;
      if (taken) begin wrsp_valid = 1'b0; wrsp_err = 1'b0; taken = 1'b0; end
      if (pend && dly == 0 && !wrsp_valid) begin
        wrsp_valid = 1'b1; wrsp_data = fuse_word(paddr); wrsp_err = pend_err; pend = 1'b0;
      end else if (pend && dly != 0) dly--;
      wreq_ready = !pend && !wrsp_valid && (s[17] || s[21]);
      #1;
      if (!rst_n) continue;
      if (stall) chk(wreq_valid && wreq_addr == stall_addr, "R9 request hold",
                     int'(wreq_addr), int'(stall_addr));
      stall = wreq_valid && !wreq_ready;
      stall_addr = wreq_addr;
      chk(!(wreq_valid && (pend || wrsp_valid)), "R6 one outstanding", int'(wreq_valid), 0);
      if (wreq_valid && wreq_ready) begin
        chk(int'(wreq_addr) == ((exp_first + req_idx) & 1023), addr_tag,
            int'(wreq_addr), (exp_first + req_idx) & 1023);
        pend = 1'b1; paddr = wreq_addr; pend_err = (req_idx == err_k);
        dly = int'(s[25:24]) % 3;
        req_idx++;
      end
      if (wrsp_valid && wrsp_ready) begin
        taken = 1'b1;
        if (wrsp_err) evt_cyc = cyc;
      end
    end
  end

  // byte sink
  initial begin
    logic [31:0] s = 32'h0BAD_F00D;
    bit          held = 1'b0;
    logic [7:0]  hd = '0;
    logic        hl = 1'b0;
    forever begin
      @(negedge clk);
      s = s * 32'd1664525 + 32'd1013904223;
      out_ready = sink_rand ? s[19] : 1'b1;
      #1;
      if (!rst_n) continue;
      if (held) chk(out_valid && out_data == hd && out_last == hl, "R9 output hold",
                    int'(out_data), int'(hd));
      held = out_valid && !out_ready;
      hd = out_data; hl = out_last;
      if (out_valid && out_ready) begin
        chk(out_data == exp_byte(exp_eff + byte_idx), (byte_idx == 0) ? "R4 head byte" : "R3 byte value",
            int'(out_data), int'(exp_byte(exp_eff + byte_idx)));
        chk(out_last == (byte_idx == exp_len - 1), "R4 last flag", int'(out_last),
            int'(byte_idx == exp_len - 1));
        if (out_last) evt_cyc = cyc;
        byte_idx++;
      end
    end
  end

  task automatic run_xfer(input int off, input int len, input bit hb, input int ek,
                          input string atag);
    int eff;
    int words;
    int nbytes;
    int waitc;
    bit got;
    eff = off + (hb ? 96 : 0);
    if (len == 0) words = 0;
    else          words = ((eff + len + 3) >> 2) - (eff >> 2);
    nbytes = len;
    if (ek >= 0) begin
      words = ek + 1;
      if (ek == 0) nbytes = 0;
      else begin
        nbytes = 4 * ek - (eff & 3);
        if (nbytes > len) nbytes = len;
      end
    end
    @(negedge clk);
    exp_eff = eff; exp_len = len; exp_first = eff >> 2; err_k = ek;
    byte_idx = 0; req_idx = 0; addr_tag = atag;
    cmd_valid = 1'b1; cmd_offset = 16'(off); cmd_len = 16'(len); hide_base = hb;
    forever begin
      #1;
      if (cmd_ready) break;
      @(negedge clk);
    end
    if (len == 0) evt_cyc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    got = 1'b0; waitc = 0;
    while (!got && waitc < 500) begin
      #1;
      if (done) got = 1'b1;
      else begin @(negedge clk); waitc++; end
    end
    chk(got, "R10 done seen", int'(got), 1);
    chk(cyc == evt_cyc + 1, (len == 0) ? "R8 done timing" : "R10 done timing", cyc, evt_cyc + 1);
    chk(!busy, "R10 idle at done", int'(busy), 0);
    chk(byte_idx == nbytes, (ek >= 0) ? "R7 byte count" : "R4 byte count", byte_idx, nbytes);
    chk(req_idx == words, (len == 0) ? "R8 request count" : "R1 request count", req_idx, words);
    chk(err == (ek >= 0), "R7 error flag", int'(err), int'(ek >= 0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cmd_ready && !busy && !done && !err && !wreq_valid && !out_valid,
        "R11 state in reset", int'({cmd_ready, busy, done, err, wreq_valid, out_valid}), 32);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cmd_ready && !busy && !done && !err && !wreq_valid && !out_valid,
        "R11 state after reset", int'({cmd_ready, busy, done, err, wreq_valid, out_valid}), 32);
    for (int hb = 0; hb < 2; hb++) begin
      for (int off = 0; off < 20; off++) begin
        for (int len = 0; len < 10; len++) begin
          sink_rand = ((off + len) % 2) == 1;
          run_xfer(off, len, hb[0], -1, (hb == 1) ? "R5 address" : "R1 address");
        end
      end
    end
    sink_rand = 1'b1;
    run_xfer(4094, 6, 1'b0, -1, "R2 wrap");
    run_xfer(65534, 4, 1'b0, -1, "R2 wrap");
    run_xfer(2, 9, 1'b0, 1, "R7 address");
    run_xfer(5, 3, 1'b1, 0, "R7 address");
    run_xfer(0, 8, 1'b0, 1, "R7 address");
    run_xfer(1, 5, 1'b0, -1, "R7 cleared");
    sink_rand = 1'b0;
    run_xfer(31, 1, 1'b1, -1, "R5 address");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule